// File: doc/BRIEF.md
# Quarter-Wave Sine Table Address Sequencer

This block produces the read address for a lookup table that stores only the first quarter of a sine period, plus a 2-bit index naming which quarter of the period each address belongs to. Each cycle in which the enable input is high counts as one sample point. On each sample point the address moves by a programmable stride. In the rising quarters (index 0 and 2) the address climbs from the bottom of the table. In the falling quarters (index 1 and 3) it descends from the top. Together, the four passes trace a full period out of a quarter-size table.

A downstream stage reads the table at the given address and uses the quarter index to decide whether to negate the sample. The output frequency equals stride × (enable rate) / 2^(ADDR_W+2). The stride is programmed as a power of two. The block keeps a count of the points taken in the current quarter and closes the quarter after exactly 2^ADDR_W / stride points. A new stride is picked up only when a quarter closes, so the points inside a quarter are always evenly spaced.

Top module: `qfold_addr_gen`

## Requirements
- R1: While `rst_n` is low, at the next clock edge `tbl_addr` becomes 0 and `quadrant` becomes 0, and the stride decoded from `step` at that edge becomes the active stride.
- R2: The `step` code decodes to a stride. A code that is a power of two is used as the stride. Code 0 means a stride of 2^STEP_W. Any other code uses only its highest set bit.
- R3: In quadrants 0 and 2, point k of the quadrant (k counted from 0) has `tbl_addr` = k × stride.
- R4: In quadrants 1 and 3, point k of the quadrant has `tbl_addr` = (2^ADDR_W − 1) − k × stride.
- R5: Each quadrant lasts exactly 2^ADDR_W / stride enabled cycles. Then `quadrant` increments by one, and it wraps from 3 to 0.
- R6: On the enabled cycle that closes a quadrant, `tbl_addr` restarts at 0 if the new quadrant is even and at 2^ADDR_W − 1 if it is odd.
- R7: A change of `step` inside a quadrant does not change the stride used for the rest of that quadrant. The `step` value present on the closing cycle sets the stride for the next quadrant.
- R8: In a cycle with `en` low, `tbl_addr`, `quadrant` and the point position all hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Advance one sample point this cycle |
| step | input | STEP_W | Stride code (power of two; 0 means 2^STEP_W) |
| tbl_addr | output | ADDR_W | Quarter-wave table read address |
| quadrant | output | 2 | Quarter of the sine period that `tbl_addr` belongs to |

## Verification
The bench uses a reduced table (6 address bits, 5-bit step code) and checks every sample point over full periods at each legal stride from 1 up to the largest. The smallest stride tests the long single-unit ramps. The largest stride, given as code 0, tests quadrants only two points long, where the restart and the turnaround sit next to each other. A non-power-of-two code shows that only its top bit is used. A stride change in the middle of a quadrant separates a design that latches the stride at the boundary from one that applies it at once. Irregular enable patterns and a reset in the middle of a run show that the address, the quadrant and the hidden point count all hold and all clear as required.

// File: rtl/qfold_pkg.sv
// Shared types for the quarter-wave address sequencer.
package qfold_pkg;
    // Quarter of the sine period; bit 0 set means the table is read downward.
    typedef enum logic [1:0] {
        Q_RISE = 2'd0,
        Q_FALL = 2'd1,
        Q_NEG  = 2'd2,
        Q_RET  = 2'd3
    } quad_t;
endpackage

// File: rtl/qfold_step_decode.sv
// Step decoder: turns the stride code into a power-of-two stride and the
// index of the last point in a quadrant (2^ADDR_W/stride - 1).
// Assumes STEP_W < ADDR_W, so every quadrant holds at least two points.
// Code 0 stands for 2^STEP_W; other codes keep only their highest set bit.
module qfold_step_decode #(
    parameter int ADDR_W = 15,
    parameter int STEP_W = 14
) (
    input  logic [STEP_W-1:0] step_code,
    output logic [ADDR_W-1:0] stride,
    output logic [ADDR_W-1:0] last_pt
);
    localparam int SH_W = $clog2(STEP_W + 1);

    logic [SH_W-1:0]   shamt;
    logic [ADDR_W:0]   pts;

    // Priority encode: the highest set bit wins; an all-zero code maps to STEP_W.
    always_comb begin
        shamt = SH_W'(STEP_W);
        for (int i = 0; i < STEP_W; i++) begin
            if (step_code[i]) shamt = SH_W'(i);
        end
    end

    // Stride and points-per-quadrant both follow from the shift amount.
    always_comb begin
        stride  = ADDR_W'(1) << shamt;
        pts     = (ADDR_W+1)'(1) << (ADDR_W - int'(shamt));
        last_pt = ADDR_W'(pts - (ADDR_W+1)'(1));
    end
endmodule

// File: rtl/qfold_quad_seq.sv
// Quadrant sequencer: counts points in the current quadrant, closes the
// quadrant after the decoded point count, advances the quadrant index and
// latches the next stride only on that closing point.
// Assumes stride/last_pt come from qfold_step_decode for the live step code.
module qfold_quad_seq
    import qfold_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] dec_stride,
    input  logic [ADDR_W-1:0] dec_last,
    output quad_t             quad,
    output logic [ADDR_W-1:0] stride_act,
    output logic              close_pt
);
    logic [ADDR_W-1:0] cnt_q;
    logic [ADDR_W-1:0] last_q;
    quad_t             quad_q;
    logic [ADDR_W-1:0] stride_q;

    // The current point is the last of its quadrant.
    always_comb close_pt = en && (cnt_q == last_q);

    // Point counter, quadrant index and stride register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            quad_q   <= Q_RISE;
            stride_q <= dec_stride;
            last_q   <= dec_last;
        end else if (close_pt) begin
            cnt_q    <= '0;
            quad_q   <= quad_t'(quad_q + 2'd1);
            stride_q <= dec_stride;
            last_q   <= dec_last;
        end else if (en) begin
            cnt_q    <= cnt_q + ADDR_W'(1);
        end
    end

    assign quad       = quad_q;
    assign stride_act = stride_q;
endmodule

// File: rtl/qfold_addr_sweep.sv
// Address sweep: moves the table address up in even quadrants and down in
// odd ones, and restarts it at the proper end when a quadrant closes.
// Assumes close_pt and quad come from qfold_quad_seq in the same cycle.
module qfold_addr_sweep
    import qfold_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              close_pt,
    input  quad_t             quad,
    input  logic [ADDR_W-1:0] stride_act,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] TOP = '1;

    logic [ADDR_W-1:0] addr_q;

    // Address register: restart on quadrant close, otherwise step in sweep direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (close_pt) begin
            addr_q <= quad[0] ? '0 : TOP;
        end else if (en) begin
            addr_q <= quad[0] ? (addr_q - stride_act) : (addr_q + stride_act);
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/qfold_addr_gen.sv
// Top level: quarter-wave sine table address sequencer. Decodes the stride
// code, sequences quadrants and drives the folded table address.
// Assumes a power-of-two stride code with STEP_W < ADDR_W.
module qfold_addr_gen
    import qfold_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int STEP_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [STEP_W-1:0] step,
    output logic [ADDR_W-1:0] tbl_addr,
    output logic [1:0]        quadrant
);
    logic [ADDR_W-1:0] dec_stride;
    logic [ADDR_W-1:0] dec_last;
    logic [ADDR_W-1:0] stride_act;
    logic              close_pt;
    quad_t             quad;

    qfold_step_decode #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_dec (
        .step_code (step),
        .stride    (dec_stride),
        .last_pt   (dec_last)
    );

    qfold_quad_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .dec_stride (dec_stride),
        .dec_last   (dec_last),
        .quad       (quad),
        .stride_act (stride_act),
        .close_pt   (close_pt)
    );

    qfold_addr_sweep #(.ADDR_W(ADDR_W)) u_sweep (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .close_pt   (close_pt),
        .quad       (quad),
        .stride_act (stride_act),
        .addr       (tbl_addr)
    );

    assign quadrant = quad;
endmodule

// File: rtl/qfold_addr_gen_chk.sv
// Checker for qfold_addr_gen: temporal properties on the address and the
// quadrant index, bound to every instance of the top module.
module qfold_addr_gen_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [ADDR_W-1:0] tbl_addr,
    input logic [1:0]        quadrant
);
    // R5: the quadrant index only ever moves forward by one, modulo 4.
    p_quad_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (quadrant != $past(quadrant))) |-> (quadrant == $past(quadrant) + 2'd1))
        else $error("p_quad_step_r5");

    // R8: with enable low, address and quadrant hold.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en)) |-> ($stable(tbl_addr) && $stable(quadrant)))
        else $error("p_hold_r8");

    // R3: inside an even quadrant the address strictly rises.
    p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && !quadrant[0] && (quadrant == $past(quadrant)))
        |-> (tbl_addr > $past(tbl_addr)))
        else $error("p_rise_r3");

    // R4: inside an odd quadrant the address strictly falls.
    p_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && quadrant[0] && (quadrant == $past(quadrant)))
        |-> (tbl_addr < $past(tbl_addr)))
        else $error("p_fall_r4");

    // R6: a new quadrant starts at the bottom (even) or top (odd) of the table.
    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (quadrant != $past(quadrant)))
        |-> (tbl_addr == (quadrant[0] ? {ADDR_W{1'b1}} : {ADDR_W{1'b0}})))
        else $error("p_restart_r6");
endmodule

bind qfold_addr_gen qfold_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .tbl_addr (tbl_addr),
    .quadrant (quadrant)
);

// File: tb/qfold_addr_gen_tb.sv
// Bench: full-period sweeps of a small configuration against an arithmetic model.
module qfold_addr_gen_tb;
    localparam int AW  = 6;
    localparam int SW  = 5;
    localparam int TOP = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en;
    logic [SW-1:0] step;
    logic [AW-1:0] tbl_addr;
    logic [1:0]    quadrant;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 0;

    // model state
    int m_k;
    int m_q;
    int m_s;

    always #2.5 clk = ~clk;

    qfold_addr_gen #(.ADDR_W(AW), .STEP_W(SW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .step     (step),
        .tbl_addr (tbl_addr),
        .quadrant (quadrant)
    );

    function automatic int dec_stride(input int code);
        int s;
        if (code == 0) return 1 << SW;
        s = 1;
        while ((s << 1) <= code) s = s << 1;
        return s;
    endfunction

    function automatic int exp_addr();
        return (m_q % 2 == 0) ? (m_k * m_s) : (TOP - m_k * m_s);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare both outputs with the model; tag chosen from context unless overridden.
    task automatic check_all(input string ovr, input bit e);
        string ta;
        if (ovr != "") ta = ovr;
        else if (!e) ta = "R8";
        else if (m_k == 0) ta = "R6";
        else if (m_q % 2 == 0) ta = "R3";
        else ta = "R4";
        check(ta, int'(tbl_addr), exp_addr());
        check((ovr != "") ? ovr : "R5", int'(quadrant), m_q);
    endtask

    // One cycle from a negedge to the next: drive, clock, update model, check.
    task automatic cyc(input bit e, input string ovr);
        en = e;
        @(posedge clk);
        if (e) begin
            m_k++;
            if (m_k == (1 << AW) / m_s) begin
                m_k = 0;
                m_q = (m_q + 1) % 4;
                m_s = dec_stride(int'(step));
            end
        end
        @(negedge clk);
        check_all(ovr, e);
    endtask

    task automatic do_reset(input int code);
        rst_n = 1'b0;
        en    = 1'b1;
        step  = SW'(code);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        m_k = 0; m_q = 0; m_s = dec_stride(code);
        check("R1", int'(tbl_addr), 0);
        check("R1", int'(quadrant), 0);
        rst_n = 1'b1;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        en    = 1'b0;
        step  = '0;
        @(negedge clk);

        // R1 + main sweeps, one full period plus a few points per stride
        for (int si = 0; si <= SW; si++) begin
            int code;
            int npts;
            code = (si == SW) ? 0 : (1 << si);
            do_reset(code);
            npts = 4 * ((1 << AW) / dec_stride(code)) + 3;
            for (int i = 0; i < npts; i++) cyc(1'b1, (code == 0) ? "R2" : "");
        end

        // R2: non-power-of-two code keeps only the top bit (12 -> 8)
        do_reset(12);
        check("R2", m_s, 8);
        for (int i = 0; i < 4 * 8 + 2; i++) cyc(1'b1, "R2");

        // R7: stride change in the middle of a quadrant waits for the boundary
        do_reset(4);
        for (int i = 0; i < 5; i++) cyc(1'b1, "");
        step = SW'(16);
        for (int i = 0; i < 11; i++) cyc(1'b1, "R7");
        check("R7", m_s, 16);
        for (int i = 0; i < 12; i++) cyc(1'b1, "R7");

        // R8: irregular enable pattern
        do_reset(2);
        for (int i = 0; i < 200; i++) cyc(((i % 3) != 0) && ((i % 7) != 5), "");

        // R1: reset in the middle of a run clears everything
        for (int i = 0; i < 9; i++) cyc(1'b1, "");
        do_reset(8);
        for (int i = 0; i < 4 * 8 + 1; i++) cyc(1'b1, "");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule